// File: doc/BRIEF.md
# Extended Single-Operand and Byte ALU

This combinational unit sits beside the main ALU of a small 16-bit load/store processor. It supplies operations that the base datapath lacks: bitwise OR, complement, increment, decrement, one-place logical and arithmetic shifts, exchange of the two bytes, sign extension of a register's low byte, and two immediate moves. One of them zero-fills the upper byte. The other sign-fills it.

The decoder drives a 4-bit operation code, two data operands and an 8-bit immediate. It also supplies the current flags, packed as {zero, negative, carry}. In the same cycle the unit returns the result and the next value of the flags. The caller writes both back. Moves and sign extension pass the flags through unchanged, so a constant can be built without disturbing a pending condition. Unused codes also pass the flags through.

Top module: `alu_ext_top`

## Requirements
- R1: Op 0 (OR) gives a|b. Op 1 (NOT) gives ~a. Op 7 (SWAP) gives {a[7:0], a[15:8]}. All three clear carry.
- R2: Op 2 (INC) gives a+1 mod 2^16, with carry set only when a is 0xFFFF. Op 3 (DEC) gives a-1 mod 2^16, with carry (borrow) set only when a is 0x0000.
- R3: Op 4 (LSL) gives a<<1 with carry set to a[15]. Op 5 (LSR) gives a>>1 with zero shifted in and carry set to a[0].
- R4: Op 6 (ASR) gives a>>1 with bit 15 kept at a[15], and carry set to a[0].
- R5: Op 8 (SEXT) keeps a[7:0] and copies a[7] into bits 15..8. For example 0x00FC becomes 0xFFFC.
- R6: Op 9 (MOVL) gives {8'h00, imm}. Op 10 (MOVN) gives {8{imm[7]}, imm}. For example imm 0x04 gives 0x0004 and imm 0xFC gives 0xFFFC.
- R7: For ops 0 to 7, the zero flag is set when the result is 0 and the negative flag equals result bit 15. The flags are ordered {Z,N,C} at bits [2:0].
- R8: Ops 8, 9 and 10 return flags_o equal to flags_i.
- R9: Op codes 11 to 15 return result 0, with flags_o equal to flags_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand, used by every register operation |
| b_i | input | 16 | Second operand, used only by OR |
| imm_i | input | 8 | Immediate for the two move operations |
| flags_i | input | 3 | Current flags {Z,N,C} |
| result_o | output | 16 | Operation result |
| flags_o | output | 3 | Next flags {Z,N,C} |

## Verification
The embedded checks assume that every input is a known value before it is compared. They also assume the inputs change only between evaluations, so they inspect settled values. The bench keeps to these conditions. It drives the inputs once per clock edge and reads the outputs half a period later. Random codes span all sixteen values, so undefined codes and flag pass-through occur alongside the defined operations. Directed vectors cover the all-ones and all-zeros operands, where the carry and borrow edges of increment and decrement lie.

// File: rtl/alu_ext_pkg.sv
package alu_ext_pkg;
  typedef enum logic [3:0] {
    OP_ORR  = 4'd0,
    OP_NOT  = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_LSL  = 4'd4,
    OP_LSR  = 4'd5,
    OP_ASR  = 4'd6,
    OP_SWAP = 4'd7,
    OP_SEXT = 4'd8,
    OP_MOVL = 4'd9,
    OP_MOVN = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/alu_ext_logic.sv
module alu_ext_logic #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] res_o
);
  import alu_ext_pkg::*;
  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = DATA_W - IMM_W;

  always_comb begin
    unique case (op_i)
      OP_ORR:  res_o = a_i | b_i;
      OP_NOT:  res_o = ~a_i;
      OP_SWAP: res_o = {a_i[HALF_W-1:0], a_i[DATA_W-1:HALF_W]};
      OP_SEXT: res_o = {{EXT_W{a_i[IMM_W-1]}}, a_i[IMM_W-1:0]};
      OP_MOVL: res_o = {{EXT_W{1'b0}}, imm_i};
      OP_MOVN: res_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_ext_arith.sv
module alu_ext_arith #(
  parameter int DATA_W = 16
) (
  input  logic              dec_i,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  logic [DATA_W:0] sum;
  // decrement as a + all-ones; borrow is the inverted carry out
  always_comb begin
    sum     = {1'b0, a_i} + (dec_i ? {1'b0, {DATA_W{1'b1}}} : {{DATA_W{1'b0}}, 1'b1});
    res_o   = sum[DATA_W-1:0];
    carry_o = dec_i ? ~sum[DATA_W] : sum[DATA_W];
  end
endmodule

// File: rtl/alu_ext_shift.sv
module alu_ext_shift #(
  parameter int DATA_W = 16
) (
  input  logic              left_i,
  input  logic              arith_i,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  logic fill;
  always_comb begin
    fill = arith_i & a_i[DATA_W-1];
    if (left_i) begin
      res_o   = {a_i[DATA_W-2:0], 1'b0};
      carry_o = a_i[DATA_W-1];
    end else begin
      res_o   = {fill, a_i[DATA_W-1:1]};
      carry_o = a_i[0];
    end
  end
endmodule

// File: rtl/alu_ext_top.sv
module alu_ext_top #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [2:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [2:0]        flags_o
);
  import alu_ext_pkg::*;

  logic [DATA_W-1:0] logic_res, arith_res, shift_res;
  logic              arith_c, shift_c;
  alu_flags_t        fin, fout;

  assign fin = alu_flags_t'(flags_i);

  alu_ext_logic #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_logic (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .res_o(logic_res)
  );

  alu_ext_arith #(.DATA_W(DATA_W)) u_arith (
    .dec_i(op_i == OP_DEC), .a_i(a_i), .res_o(arith_res), .carry_o(arith_c)
  );

  alu_ext_shift #(.DATA_W(DATA_W)) u_shift (
    .left_i(op_i == OP_LSL), .arith_i(op_i == OP_ASR), .a_i(a_i),
    .res_o(shift_res), .carry_o(shift_c)
  );

  always_comb begin
    result_o = logic_res;
    fout     = fin;
    unique case (op_i)
      OP_INC, OP_DEC: begin
        result_o = arith_res;
        fout.c   = arith_c;
      end
      OP_LSL, OP_LSR, OP_ASR: begin
        result_o = shift_res;
        fout.c   = shift_c;
      end
      OP_ORR, OP_NOT, OP_SWAP: fout.c = 1'b0;
      default: ;
    endcase
    if (op_i <= OP_SWAP) begin
      fout.z = (result_o == '0);
      fout.n = result_o[DATA_W-1];
    end
  end

  assign flags_o = fout;

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i, imm_i, flags_i})) begin
      if (op_i == OP_INC)
        assert_inc_carry_R2: assert (flags_o[0] == (a_i == '1));
      if (op_i == OP_DEC)
        assert_dec_borrow_R2: assert (flags_o[0] == (a_i == '0));
      if (op_i == OP_ASR)
        assert_asr_sign_R4: assert (result_o[DATA_W-1] == a_i[DATA_W-1]);
      if (op_i == OP_SEXT)
        assert_sext_fill_R5: assert (result_o[DATA_W-1:IMM_W] == {(DATA_W-IMM_W){a_i[IMM_W-1]}});
      if (op_i inside {OP_SEXT, OP_MOVL, OP_MOVN})
        assert_flags_hold_R8: assert (flags_o == flags_i);
      if (op_i > OP_MOVN)
        assert_undef_op_R9: assert (result_o == '0 && flags_o == flags_i);
      if (op_i <= OP_SWAP)
        assert_zero_flag_R7: assert (flags_o[2] == (result_o == '0));
    end
  end
endmodule

// File: tb/sim_alu_ext_top.sv
module sim_alu_ext_top;
  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [15:0] a, b, res;
  logic [7:0]  imm;
  logic [2:0]  fl_in, fl_out;
  int n_vec = 0, n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_ext_top u0 (
    .op_i(op), .a_i(a), .b_i(b), .imm_i(imm), .flags_i(fl_in),
    .result_o(res), .flags_o(fl_out)
  );

  function automatic logic [18:0] model(input logic [3:0] o, input logic [15:0] x,
                                        input logic [15:0] y, input logic [7:0] im,
                                        input logic [2:0] f);
    logic [15:0] r; logic c; logic upd;
    r = 16'h0; c = f[0]; upd = 1'b1;
    case (o)
      4'd0: begin r = x | y; c = 1'b0; end
      4'd1: begin r = ~x; c = 1'b0; end
      4'd2: begin r = x + 16'd1; c = (x == 16'hFFFF); end
      4'd3: begin r = x - 16'd1; c = (x == 16'h0000); end
      4'd4: begin r = {x[14:0], 1'b0}; c = x[15]; end
      4'd5: begin r = {1'b0, x[15:1]}; c = x[0]; end
      4'd6: begin r = {x[15], x[15:1]}; c = x[0]; end
      4'd7: begin r = {x[7:0], x[15:8]}; c = 1'b0; end
      4'd8: begin r = {{8{x[7]}}, x[7:0]}; upd = 1'b0; end
      4'd9: begin r = {8'h00, im}; upd = 1'b0; end
      4'd10: begin r = {{8{im[7]}}, im}; upd = 1'b0; end
      default: upd = 1'b0;
    endcase
    if (upd) return {r, (r == 16'h0), r[15], c};
    return {r, f};
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0, 4'd1, 4'd7: return "R1/R7";
      4'd2, 4'd3: return "R2/R7";
      4'd4, 4'd5: return "R3/R7";
      4'd6: return "R4/R7";
      4'd8: return "R5/R8";
      4'd9, 4'd10: return "R6/R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                       input logic [7:0] im, input logic [2:0] f);
    logic [18:0] exp;
    @(posedge clk);
    op = o; a = x; b = y; imm = im; fl_in = f;
    @(negedge clk);
    exp = model(o, x, y, im, f);
    n_vec++;
    if ({res, fl_out} !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h imm=%h: got %h/%b expected %h/%b",
               tag(o), o, x, im, res, fl_out, exp[18:3], exp[2:0]);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1bad5eed;
    void'($urandom(seed));
    op = 4'd0; a = '0; b = '0; imm = '0; fl_in = '0;
    // directed corners
    apply(4'd8, 16'h00FC, 16'h0, 8'h00, 3'b101);   // R5 example
    apply(4'd10, 16'h0, 16'h0, 8'h04, 3'b010);     // R6 +4
    apply(4'd10, 16'h0, 16'h0, 8'hFC, 3'b000);     // R6 -4
    apply(4'd9, 16'hFFFF, 16'h0, 8'hFC, 3'b111);   // R6 zero fill, R8
    apply(4'd2, 16'hFFFF, 16'h0, 8'h00, 3'b000);   // R2 wrap, carry
    apply(4'd3, 16'h0000, 16'h0, 8'h00, 3'b000);   // R2 borrow
    apply(4'd3, 16'h0001, 16'h0, 8'h00, 3'b001);   // R2 to zero, R7
    apply(4'd6, 16'h8001, 16'h0, 8'h00, 3'b000);   // R4
    apply(4'd5, 16'h8001, 16'h0, 8'h00, 3'b000);   // R3
    apply(4'd4, 16'h8000, 16'h0, 8'h00, 3'b000);   // R3 carry, zero
    apply(4'd7, 16'h12AB, 16'h0, 8'h00, 3'b001);   // R1 swap
    apply(4'd0, 16'h0000, 16'h0000, 8'h00, 3'b001);// R1/R7 zero
    apply(4'd1, 16'hFFFF, 16'h0, 8'h00, 3'b001);   // R1 not
    for (int k = 11; k < 16; k++)
      apply(4'(k), 16'hBEEF, 16'h1234, 8'h80, 3'b101); // R9
    for (int i = 0; i < 3000; i++)
      apply(4'($urandom), 16'($urandom), 16'($urandom), 8'($urandom), 3'($urandom));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule